// File: doc/BRIEF.md
# Interrupt Moderation Delay Timer

This block sits between the completion events of a network datapath and the interrupt request line of a host CPU. Its job is to let several completions share one interrupt. It holds each interrupt back for a programmable time and then spaces successive interrupts apart. Software supplies three values on plain register inputs: a packet delay, an absolute delay and a throttle gap.

A packet timer starts again on every event, so a burst of traffic keeps pushing the interrupt later. An absolute timer starts on the first event after an interrupt and is never reloaded, which puts an upper bound on the added latency. When either timer expires, an interrupt becomes pending and both timers stop. A throttle then keeps the request low until a minimum gap, measured from the previous assertion, has passed. The request is a level and stays high until the host acknowledges it.

The two delays count in 1.024 µs ticks and the throttle counts in 256 ns ticks. Parameters set the number of clock cycles per tick, so a bench can shorten both.

Top module: `irq_moderator`

## Requirements
- R1: After reset `irq_o` is low and no throttle gap is pending. The first interrupt after reset is held back only by the delay timers.
- R2: With a non-zero packet delay D and a single event, `irq_o` rises exactly D*US_TICK_CYC+1 clock edges after the edge that samples `evt_i`.
- R3: Each event reloads the packet timer. With a non-zero packet delay D and no earlier absolute expiry, `irq_o` rises D*US_TICK_CYC+1 edges after the last event of a burst.
- R4: A packet delay of zero turns both timers off. Every event then makes the interrupt pending at once, and `irq_o` rises one edge after the event, whatever the absolute delay is.
- R5: A non-zero absolute delay A is armed only by an event that finds the absolute timer idle, and later events do not reload it. `irq_o` rises at the earlier of A*US_TICK_CYC+1 edges after the first event and the packet expiry. An absolute delay of zero turns this timer off.
- R6: When the interrupt becomes pending, both timers stop. Without a new event, no further interrupt follows the acknowledged one.
- R7: `irq_o` stays high until `ack_i` is sampled high, and it is low on the cycle after that edge.
- R8: An event that arrives while `irq_o` is high arms the timers for the next interrupt. That interrupt rises at the later of its own timer expiry and one edge after the acknowledge.
- R9: Two rising edges of `irq_o` are at least T*THR_TICK_CYC edges apart, where T is `gap_i` taken when the first of them rose. A throttle value of zero enforces no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 1 | One-cycle pulse for each packet completion |
| ack_i | input | 1 | One-cycle pulse from the host that acknowledges the interrupt |
| pkt_dly_i | input | 16 | Packet delay in 1.024 µs ticks; 0 turns the timers off |
| abs_dly_i | input | 16 | Absolute delay in 1.024 µs ticks; 0 turns this timer off |
| gap_i | input | 16 | Minimum gap between interrupts in 256 ns ticks; 0 means no gap |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is the absolute timer winning against a packet timer that keeps being reloaded. To get there, the bench sends bursts of events spaced closer together than the packet delay. It sweeps the absolute delay so that its expiry falls before, between and after the possible packet expiries. No event is sent on or after the absolute expiry, so each expected edge follows from the arithmetic. The throttle is reached in a similar way: an acknowledge and a zero-delay event follow the first assertion at once, so the gap rather than the event sets the second rising edge, and the gap is swept through values on both sides of that crossover.

// File: rtl/irqm_pkg.sv
// Package: widths and default tick lengths shared by the moderator modules.
// Assumes a 250 MHz system clock for the default tick lengths.
package irqm_pkg;
    localparam int DLY_W            = 16;   // delay value width
    localparam int GAP_W            = 16;   // throttle value width
    localparam int DEF_US_TICK_CYC  = 256;  // 1.024 us at 4 ns per cycle
    localparam int DEF_THR_TICK_CYC = 64;   // 256 ns at 4 ns per cycle
endpackage

// File: rtl/irqm_tick_div.sv
// Tick divider: gives one tick every CYC enabled cycles.
// Assumes clr_i restarts the phase, so the first tick comes CYC cycles after a clear.
module irqm_tick_div #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC - 1);

    logic [PW-1:0] phase_q;

    assign tick_o = en_i && (phase_q == LAST);

    // Phase counter: restarts on clear, wraps on tick, advances while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  phase_q <= '0;
        else if (tick_o)      phase_q <= '0;
        else if (en_i)        phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/irqm_delay_timer.sv
// Delay timer: counts a loaded value down in ticks and pulses expire_o on the last tick.
// RESTART=1 reloads on every start, and RESTART=0 loads only while idle.
// Assumes that a zero delay never arms the timer and that clear_i wins over a load.
module irqm_delay_timer #(
    parameter int W        = 16,
    parameter int TICK_CYC = 4,
    parameter bit RESTART  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         clear_i,
    input  logic [W-1:0] dly_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;
    logic         load;
    logic         tick;
    logic         running;

    assign running = (cnt_q != '0);

    generate
        if (RESTART) begin : g_restart
            assign load = start_i && (dly_i != '0);
        end else begin : g_oneshot
            assign load = start_i && (dly_i != '0) && !running;
        end
    endgenerate

    irqm_tick_div #(.CYC(TICK_CYC)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (running),
        .clr_i  (load || clear_i),
        .tick_o (tick)
    );

    assign expire_o = tick && (cnt_q == W'(1));

    // Remaining tick count: clear, then load, then count down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clear_i)  cnt_q <= '0;
        else if (load)     cnt_q <= dly_i;
        else if (tick)     cnt_q <= cnt_q - 1'b1;
    end

    // R2: the count holds between ticks unless it is loaded or cleared
    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick && !load && !clear_i) |=> $stable(cnt_q));

    generate
        if (!RESTART) begin : g_chk_oneshot
            // R5: a running one-shot timer never moves upward
            p_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (running && !clear_i) |=> (cnt_q <= $past(cnt_q)));
        end
    endgenerate
endmodule

// File: rtl/irqm_throttle.sv
// Throttle: after start_i, holds ok_o low until gap_i ticks have passed.
// Assumes that ok_o rises in the cycle of the last tick, so the spacing is exactly gap*TICK_CYC edges.
module irqm_throttle #(
    parameter int W        = 16,
    parameter int TICK_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] gap_i,
    output logic         ok_o
);
    logic [W-1:0] left_q;
    logic         tick;

    irqm_tick_div #(.CYC(TICK_CYC)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (left_q != '0),
        .clr_i  (start_i),
        .tick_o (tick)
    );

    assign ok_o = (left_q == '0) || ((left_q == W'(1)) && tick);

    // Ticks left in the gap: load at an assertion, count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                  left_q <= '0;
        else if (start_i)            left_q <= gap_i;
        else if (tick)               left_q <= left_q - 1'b1;
    end

    // R9: no new assertion may start while a gap is still running
    p_gap_respected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q > W'(1)) |-> !start_i);
endmodule

// File: rtl/irq_moderator.sv
// Interrupt moderator: merges packet events into throttled level interrupts.
// Assumes that evt_i and ack_i are single-cycle pulses in the clk domain and that the
// delay inputs are quasi-static. An event on the same cycle as a timer expiry is merged
// into the interrupt that expiry raises.
module irq_moderator
    import irqm_pkg::*;
#(
    parameter int US_TICK_CYC  = DEF_US_TICK_CYC,
    parameter int THR_TICK_CYC = DEF_THR_TICK_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             ack_i,
    input  logic [DLY_W-1:0] pkt_dly_i,
    input  logic [DLY_W-1:0] abs_dly_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             irq_o
);
    logic pkt_exp, abs_exp, timers_clr;
    logic direct, abs_start;
    logic thr_ok, irq_set;
    logic pend_q, irq_q;

    assign direct     = evt_i && (pkt_dly_i == '0);
    assign abs_start  = evt_i && (pkt_dly_i != '0);
    assign timers_clr = pkt_exp || abs_exp;

    irqm_delay_timer #(.W(DLY_W), .TICK_CYC(US_TICK_CYC), .RESTART(1'b1)) u_pkt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (evt_i),
        .clear_i  (timers_clr),
        .dly_i    (pkt_dly_i),
        .expire_o (pkt_exp)
    );

    irqm_delay_timer #(.W(DLY_W), .TICK_CYC(US_TICK_CYC), .RESTART(1'b0)) u_abs (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (abs_start),
        .clear_i  (timers_clr),
        .dly_i    (abs_dly_i),
        .expire_o (abs_exp)
    );

    irqm_throttle #(.W(GAP_W), .TICK_CYC(THR_TICK_CYC)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (irq_set),
        .gap_i   (gap_i),
        .ok_o    (thr_ok)
    );

    assign irq_set = pend_q && !irq_q && thr_ok;

    // Pending flag: set by an expiry or a direct event, consumed when the request rises.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (irq_set)  pend_q <= 1'b0;
        else if (timers_clr || direct) pend_q <= 1'b1;
    end

    // Request level: cleared by an acknowledge, set when pending and the gap has passed.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (ack_i)    irq_q <= 1'b0;
        else if (irq_set)  irq_q <= 1'b1;
    end

    assign irq_o = irq_q;

    // R7: an acknowledge drops the request on the next cycle
    p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && ack_i) |=> !irq_q);

    // R7: without an acknowledge the request holds
    p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack_i) |=> irq_q);

    // R4: a zero-delay event leaves an interrupt pending or raised
    p_direct_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && pkt_dly_i == '0) |=> (pend_q || irq_q));

    // R6: a rise of the request always consumes a pending interrupt
    p_rise_from_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(pend_q));
endmodule

// File: tb/irq_moderator_test.sv
`timescale 1ns/1ps
module irq_moderator_test;
    localparam int US = 4;
    localparam int TH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_i = 1'b0;
    logic ack_i = 1'b0;
    logic [15:0] pkt_dly_i = '0;
    logic [15:0] abs_dly_i = '0;
    logic [15:0] gap_i = '0;
    logic irq_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    irq_moderator #(.US_TICK_CYC(US), .THR_TICK_CYC(TH)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ack_i(ack_i),
        .pkt_dly_i(pkt_dly_i), .abs_dly_i(abs_dly_i), .gap_i(gap_i), .irq_o(irq_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_evt(output int e);
        evt_i = 1'b1;
        @(negedge clk);
        evt_i = 1'b0;
        e = cyc;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic wait_irq(output int r);
        int n = 0;
        while (!irq_o && n < 600) begin
            @(negedge clk);
            n++;
        end
        r = irq_o ? cyc : -1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_o) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    task automatic settle();
        if (irq_o) do_ack();
        idle(40);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        int e, e1, el, r, r1, r2, a, expv, span;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state
        chk(irq_o == 1'b0, "R1 reset level", irq_o, 0);

        // R1: the first interrupt after reset sees no throttle gap
        gap_i = 16'd8; pkt_dly_i = '0;
        pulse_evt(e);
        wait_irq(r);
        chk(r == e + 1, "R1 first irq ungated", r, e + 1);
        settle();
        gap_i = '0;

        // R2: single-event latency sweep; R7 ack; R6 no repeat
        for (int d = 1; d <= 8; d++) begin
            pkt_dly_i = 16'(d); abs_dly_i = '0;
            pulse_evt(e);
            wait_irq(r);
            chk(r == e + d * US + 1, "R2 packet delay", r - e, d * US + 1);
            do_ack();
            chk(irq_o == 1'b0, "R7 ack clears", irq_o, 0);
            quiet(40, "R6 no repeat");
        end

        // R4: zero packet delay is immediate regardless of absolute delay
        for (int av = 0; av <= 3; av++) begin
            pkt_dly_i = '0; abs_dly_i = 16'(av);
            pulse_evt(e);
            wait_irq(r);
            chk(r == e + 1, "R4 immediate", r - e, 1);
            settle();
        end

        // R3: burst with spacing below the packet delay restarts the timer
        for (int s = 2; s <= 11; s++) begin
            pkt_dly_i = 16'd3; abs_dly_i = '0;
            for (int j = 0; j < 3; j++) begin
                if (j > 0) idle(s - 1);
                pulse_evt(e);
            end
            wait_irq(r);
            chk(r == e + 3 * US + 1, "R3 restart", r - e, 3 * US + 1);
            settle();
        end

        // R5: absolute delay sweep against a reloaded packet timer
        for (int av = 0; av <= 8; av++) begin
            pkt_dly_i = 16'd3; abs_dly_i = 16'(av);
            e1 = 0; el = 0;
            for (int j = 0; j < 3; j++) begin
                if (av == 0 || 8 * j < 4 * av) begin
                    if (j > 0) idle(7);
                    pulse_evt(e);
                    if (j == 0) e1 = e;
                    el = e;
                end
            end
            span = (el - e1) + 3 * US;
            if (av != 0 && av * US < span) span = av * US;
            expv = e1 + span + 1;
            wait_irq(r);
            chk(r == expv, "R5 absolute bound", r - e1, span + 1);
            settle();
        end

        // R8/R7: event while asserted, late acknowledge
        pkt_dly_i = 16'd2; abs_dly_i = '0; gap_i = '0;
        pulse_evt(e1);
        wait_irq(r1);
        chk(r1 == e1 + 2 * US + 1, "R8 first irq", r1 - e1, 2 * US + 1);
        idle(2);
        pulse_evt(e);
        begin
            int lows = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!irq_o) lows++;
            end
            chk(lows == 0, "R7 level held", lows, 0);
        end
        do_ack();
        a = cyc;
        chk(irq_o == 1'b0, "R7 ack clears", irq_o, 0);
        wait_irq(r2);
        chk(r2 == a + 1, "R8 rise after ack", r2 - a, 1);
        settle();

        // R8: event while asserted, early acknowledge
        pulse_evt(e1);
        wait_irq(r1);
        idle(1);
        pulse_evt(e);
        idle(1);
        do_ack();
        chk(irq_o == 1'b0, "R7 ack clears", irq_o, 0);
        wait_irq(r2);
        chk(r2 == e + 2 * US + 1, "R8 rise by timer", r2 - e, 2 * US + 1);
        settle();

        // R9: throttle sweep
        for (int t = 0; t <= 8; t++) begin
            pkt_dly_i = '0; abs_dly_i = '0; gap_i = 16'(t);
            pulse_evt(e1);
            wait_irq(r1);
            chk(r1 == e1 + 1, "R9 first irq", r1 - e1, 1);
            do_ack();
            pulse_evt(e);
            wait_irq(r2);
            expv = e + 1;
            if (r1 + t * TH > expv) expv = r1 + t * TH;
            chk(r2 == expv, "R9 gap", r2 - r1, expv - r1);
            settle();
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end
endmodule